// File: doc/BRIEF.md
# Change-of-State Digital I/O Register Bank

This block is the byte-wide register file of a digital I/O card. It holds latches for 24 output lines and for 8 TTL lines whose direction can be switched. It returns the current state of 24 isolated input lines and of the TTL lines. It watches the 32 input lines in four banks of eight and records edges, so that a host can be interrupted when an input changes.

The host uses a simple strobe bus with an 8-bit address and 8-bit read and write data. Reads are combinational: `rdata` is valid in the same cycle as `rd_en`. Writes take effect at the clock edge that samples `wr_en`. All input lines pass through a two-flop synchronizer before they are read back or checked for edges. Edge recording is enabled per bank and per direction. Recorded edges stay in sticky status bits, which the host clears by writing ones to them. The single interrupt line stays high while any status bit is set.

Top module: `cos_dio_regbank`

## Requirements
- R1: After hardware reset, every output latch, status bit, the direction bit and the edge-enable byte are 0. `irq` is low, `ttl_oe` is low and every readable location returns 0 while the inputs are low.
- R2: Writes to 0x0, 0x1 and 0x2 load `out_pins[7:0]`, `[15:8]` and `[23:16]`, and writes to 0x3 load `ttl_out`. Reading the same address returns the latch.
- R3: Reads of 0x4, 0x5 and 0x6 return `iso_in` bytes 0 to 2, and reads of 0x7 return `ttl_in`, in both cases after a two-flop synchronizer. Writes to 0x4 to 0x7 change nothing.
- R4: Bit 1 of address 0xC is the TTL direction: 1 drives `ttl_oe` high (output mode) and 0 selects input mode. The other bits of 0xC read as 0. In output mode a read of 0x7 returns the TTL latch.
- R5: When bit n of the enable byte at 0xE is 1, a rising edge on a line of bank n sets that line's status bit. Bank 0 to 2 are `iso_in` bytes 0 to 2, bank 3 is `ttl_in`, and the status for bank n is read at 0x8+n, one bit per line.
- R6: When bit n+4 of the enable byte is 1, a falling edge on a line of bank n sets that line's status bit.
- R7: An edge whose direction is not enabled for its bank leaves the status unchanged.
- R8: Writing 1 to a status bit at 0x8 to 0xB clears it. Writing 0 leaves it unchanged.
- R9: If an enabled edge arrives in the same cycle as a write that clears its bit, the bit stays set.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: Any write to 0xF clears all output latches, status bits, the direction bit and the enable byte at that clock edge.
- R12: Address 0xD, address 0xF on read, and every address from 0x10 upward read as 0, and writes to 0xD or to 0x10 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irq | output | 1 | Interrupt, OR of all status bits |
| out_pins | output | 24 | Output line latches |
| iso_in | input | 24 | Isolated input lines |
| ttl_in | input | 8 | TTL pin state |
| ttl_out | output | 8 | TTL output latch |
| ttl_oe | output | 1 | TTL output enable (direction) |

## Verification
A register write shows at its output port and on readback one clock edge after the strobe is sampled. Read data is combinational, so the bench samples it one time unit after setting the address, away from any edge. An input change reaches the readback locations two edges after it is driven, and reaches the status bits and `irq` on the third edge. After driving inputs the bench therefore waits three rising edges and samples at the next falling edge. For the collision case, the bench times the clearing write so that it is sampled at exactly that third edge.

// File: rtl/cos_dio_pkg.sv
package cos_dio_pkg;
    localparam int LINES_PER_BANK = 8;
    localparam int ISO_BANKS      = 3;
    localparam int NUM_BANKS      = ISO_BANKS + 1;
    localparam int ISO_W          = ISO_BANKS * LINES_PER_BANK;
    localparam int ALL_W          = NUM_BANKS * LINES_PER_BANK;

    localparam logic [3:0] A_OUT0   = 4'h0;
    localparam logic [3:0] A_TTLOUT = 4'h3;
    localparam logic [3:0] A_IN0    = 4'h4;
    localparam logic [3:0] A_TTLIN  = 4'h7;
    localparam logic [3:0] A_STAT0  = 4'h8;
    localparam logic [3:0] A_CTRL   = 4'hC;
    localparam logic [3:0] A_EDGEEN = 4'hE;
    localparam logic [3:0] A_SRST   = 4'hF;
    localparam int         DIR_BIT  = 1;

    typedef struct packed {
        logic out_lat;
        logic ttl_lat;
        logic stat_ack;
        logic ctrl;
        logic edge_en;
        logic srst;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic wr, input logic [7:0] a);
        wr_dec_t d;
        logic    hit;
        hit        = wr && (a[7:4] == 4'h0);
        d.out_lat  = hit && (a[3:0] <  A_TTLOUT);
        d.ttl_lat  = hit && (a[3:0] == A_TTLOUT);
        d.stat_ack = hit && (a[3:2] == A_STAT0[3:2]);
        d.ctrl     = hit && (a[3:0] == A_CTRL);
        d.edge_en  = hit && (a[3:0] == A_EDGEEN);
        d.srst     = hit && (a[3:0] == A_SRST);
        return d;
    endfunction
endpackage

// File: rtl/cos_dio_sync.sv
module cos_dio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            dout   <= '0;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/cos_dio_edge_bank.sv
module cos_dio_edge_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srst,
    input  logic [WIDTH-1:0] lines,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic [WIDTH-1:0] ack,
    output logic [WIDTH-1:0] status
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;

    always_comb begin
        hit = ({WIDTH{rise_en}} & lines & ~prev_q)
            | ({WIDTH{fall_en}} & ~lines & prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    always_ff @(posedge clk) begin
        if (rst || srst) status <= '0;
        else             status <= (status & ~ack) | hit;
    end
endmodule

// File: rtl/cos_dio_regbank.sv
module cos_dio_regbank
    import cos_dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              irq,
    output logic [ISO_W-1:0]  out_pins,
    input  logic [ISO_W-1:0]  iso_in,
    input  logic [LINES_PER_BANK-1:0] ttl_in,
    output logic [LINES_PER_BANK-1:0] ttl_out,
    output logic              ttl_oe
);
    localparam int LB = LINES_PER_BANK;

    wr_dec_t          dec;
    logic [ALL_W-1:0] lines_s;
    logic [ALL_W-1:0] status;
    logic [7:0]       edge_en_q;
    logic             dir_q;

    assign dec = decode_wr(wr_en, addr);

    cos_dio_sync #(.WIDTH(ALL_W)) sync_i (
        .clk (clk),
        .rst (rst),
        .din ({ttl_in, iso_in}),
        .dout(lines_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [LB-1:0] ack_b;
        assign ack_b = (dec.stat_ack && (addr[1:0] == 2'(b))) ? wdata[LB-1:0] : '0;
        cos_dio_edge_bank #(.WIDTH(LB)) edge_i (
            .clk    (clk),
            .rst    (rst),
            .srst   (dec.srst),
            .lines  (lines_s[b*LB +: LB]),
            .rise_en(edge_en_q[b]),
            .fall_en(edge_en_q[b+4]),
            .ack    (ack_b),
            .status (status[b*LB +: LB])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || dec.srst) begin
            out_pins  <= '0;
            ttl_out   <= '0;
            dir_q     <= 1'b0;
            edge_en_q <= '0;
        end else begin
            if (dec.out_lat) out_pins[int'(addr[1:0])*LB +: LB] <= wdata[LB-1:0];
            if (dec.ttl_lat) ttl_out   <= wdata[LB-1:0];
            if (dec.ctrl)    dir_q     <= wdata[DIR_BIT];
            if (dec.edge_en) edge_en_q <= wdata;
        end
    end

    assign ttl_oe = dir_q;
    assign irq    = |status;

    always_comb begin
        rdata = '0;
        if (rd_en && addr[7:4] == 4'h0) begin
            unique case (addr[3:2])
                2'b00: begin
                    if (addr[1:0] == A_TTLOUT[1:0]) rdata = ttl_out;
                    else                            rdata = out_pins[int'(addr[1:0])*LB +: LB];
                end
                2'b01: begin
                    if (addr[1:0] == A_TTLIN[1:0]) rdata = dir_q ? ttl_out : lines_s[ISO_W +: LB];
                    else                           rdata = lines_s[int'(addr[1:0])*LB +: LB];
                end
                2'b10: rdata = status[int'(addr[1:0])*LB +: LB];
                default: begin
                    if (addr[3:0] == A_CTRL)        rdata[DIR_BIT] = dir_q;
                    else if (addr[3:0] == A_EDGEEN) rdata = edge_en_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/cos_dio_regbank_chk.sv
module cos_dio_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  addr,
    input logic [7:0]  wdata,
    input logic        wr_en,
    input logic        irq,
    input logic [23:0] out_pins,
    input logic [7:0]  ttl_out,
    input logic        ttl_oe
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (out_pins == '0 && ttl_out == '0 && !ttl_oe && !irq)); // R1

    AST_OUT0_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h00) |=> (out_pins[7:0] == $past(wdata))); // R2

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h0C) |=> (ttl_oe == $past(wdata[1]))); // R4

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && (addr[7:2] == 6'h02 || addr == 8'h0F))) |=> irq); // R10

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h0F) |=> (out_pins == '0 && ttl_out == '0 && !ttl_oe && !irq)); // R11

    AST_HOLE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == 8'h0D || addr[7:4] != 4'h0))
        |=> ($stable(out_pins) && $stable(ttl_out) && $stable(ttl_oe))); // R12
endmodule

bind cos_dio_regbank cos_dio_regbank_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .irq     (irq),
    .out_pins(out_pins),
    .ttl_out (ttl_out),
    .ttl_oe  (ttl_oe)
);

// File: tb/cos_dio_regbank_tb_top.sv
module cos_dio_regbank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {requirement, address, write data, expected readback}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd2,  8'h00, 8'hA5, 8'hA5},  // R2
        {8'd2,  8'h01, 8'h3C, 8'h3C},  // R2
        {8'd2,  8'h02, 8'hF0, 8'hF0},  // R2
        {8'd2,  8'h03, 8'h81, 8'h81},  // R2
        {8'd3,  8'h04, 8'hFF, 8'h00},  // R3 read-only
        {8'd3,  8'h07, 8'hFF, 8'h00},  // R3 read-only
        {8'd12, 8'h0D, 8'h77, 8'h00},  // R12
        {8'd5,  8'h0E, 8'h5A, 8'h5A},  // R5 enable byte
        {8'd7,  8'h0E, 8'h00, 8'h00},  // R7 disable again
        {8'd4,  8'h0C, 8'hFF, 8'h02}   // R4 only direction bit
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] addr = '0, wdata = '0, rdata;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic irq, ttl_oe;
    logic [23:0] out_pins, iso_in = '0;
    logic [7:0]  ttl_in = '0, ttl_out, rv;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_dio_regbank dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .irq(irq), .out_pins(out_pins),
        .iso_in(iso_in), .ttl_in(ttl_in), .ttl_out(ttl_out), .ttl_oe(ttl_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(8'(a), rv);
            chk("R1", rv, 0);
        end
        chk("R1 irq", irq, 0);
        chk("R1 ttl_oe", ttl_oe, 0);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], rv);
            chk($sformatf("R%0d vec%0d", VEC[i][31:24], i), rv, VEC[i][7:0]);
        end
        chk("R2 pins", out_pins, 24'hF03CA5);
        chk("R2 ttl_out", ttl_out, 8'h81);
        chk("R4 oe", ttl_oe, 1);
        rd(8'h07, rv); chk("R4 readback latch", rv, 8'h81);
        wr(8'h0C, 8'h00);
        chk("R4 oe off", ttl_oe, 0);

        // R3 inputs readback
        iso_in = 24'h123456; ttl_in = 8'h66;
        settle();
        rd(8'h04, rv); chk("R3 in0", rv, 8'h56);
        rd(8'h05, rv); chk("R3 in1", rv, 8'h34);
        rd(8'h06, rv); chk("R3 in2", rv, 8'h12);
        rd(8'h07, rv); chk("R3 ttl", rv, 8'h66);
        // R7 edges with nothing enabled
        rd(8'h08, rv); chk("R7 stat0", rv, 0);
        rd(8'h0B, rv); chk("R7 stat3", rv, 0);
        chk("R7 irq", irq, 0);

        // R5 rising, bank 0
        wr(8'h0E, 8'h01);
        @(negedge clk) iso_in = 24'h123457;
        settle();
        rd(8'h08, rv); chk("R5 rise", rv, 8'h01);
        chk("R10 irq set", irq, 1);
        @(negedge clk) iso_in = 24'h123456;
        settle();
        rd(8'h08, rv); chk("R7 fall disabled", rv, 8'h01);

        // R8 write-one-to-clear
        wr(8'h08, 8'h00);
        rd(8'h08, rv); chk("R8 zero keeps", rv, 8'h01);
        wr(8'h08, 8'h01);
        rd(8'h08, rv); chk("R8 one clears", rv, 8'h00);
        chk("R10 irq clear", irq, 0);

        // R6 falling, bank 3
        wr(8'h0E, 8'h80);
        @(negedge clk) ttl_in = 8'h60;
        settle();
        rd(8'h0B, rv); chk("R6 fall", rv, 8'h06);
        chk("R10 irq ttl", irq, 1);
        @(negedge clk) ttl_in = 8'h61;
        settle();
        rd(8'h0B, rv); chk("R7 rise disabled", rv, 8'h06);
        wr(8'h0B, 8'hFF);

        // R9 edge wins over clear
        wr(8'h0E, 8'h11);
        @(negedge clk) iso_in = 24'h123457;
        settle();
        rd(8'h08, rv); chk("R9 pre", rv, 8'h01);
        @(negedge clk) iso_in = 24'h123456;
        repeat (2) @(posedge clk);
        wr(8'h08, 8'h01);
        rd(8'h08, rv); chk("R9 collision", rv, 8'h01);
        wr(8'h08, 8'h01);
        rd(8'h08, rv); chk("R9 later clear", rv, 8'h00);

        // R11 soft reset
        wr(8'h00, 8'hEE); wr(8'h03, 8'h5C); wr(8'h0C, 8'h02);
        @(negedge clk) iso_in = 24'h123457;
        settle();
        chk("R11 pre irq", irq, 1);
        wr(8'h0F, 8'h00);
        chk("R11 pins", out_pins, 0);
        chk("R11 ttl_out", ttl_out, 0);
        chk("R11 oe", ttl_oe, 0);
        chk("R11 irq", irq, 0);
        rd(8'h0E, rv); chk("R11 enable", rv, 0);

        // R12 holes and upper addresses
        wr(8'h13, 8'hAA);
        wr(8'h10, 8'h55);
        wr(8'h2C, 8'h02);
        chk("R12 ttl_out", ttl_out, 0);
        chk("R12 pins", out_pins, 0);
        chk("R12 oe", ttl_oe, 0);
        rd(8'h10, rv); chk("R12 read hi", rv, 0);
        rd(8'h0F, rv); chk("R12 read F", rv, 0);
        rd(8'h0D, rv); chk("R12 read D", rv, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule